// File: doc/BRIEF.md
# Exception Cause Priority Classifier

This block turns a snapshot of processor state, taken when an exception is accepted, into one 4-bit cause code. It looks at the saved copy of the previous interrupt-enable bit, the vector of pending interrupt lines, a set of decode flags for the faulting instruction, and the two divide operands. It resolves them through a fixed ladder of checks: hardware interrupt first, then the instruction-related causes, with unknown as the fallback.

The code is available combinationally on `cause_now` at all times. A single-cycle (or longer) exception-taken strobe copies it into a cause register, which holds its value between strobes. A handler can then branch on the registered code without decoding the instruction again.

Top module: `exc_cause_classifier`

## Requirements
- R1: While reset is active, and after it until the first strobe, `cause_q` reads 0, the "none" code.
- R2: When `prev_ie` is 1 and `irq_pend` has any bit set, `cause_now` is 1 (hardware interrupt), whatever the instruction flags and operands are.
- R3: When `prev_ie` is 0 or `irq_pend` is all zeros, no interrupt cause is reported and the instruction checks decide the code.
- R4: Among the instruction flags, `is_trap` gives 2 and wins over all others. `is_ldst` gives 3 and wins over all except trap. `is_xfer` (branch, register call, exception return, jump or return) gives 4 and wins over the remaining flags.
- R5: `is_unimp` gives 5 and wins over `is_illegal`, which gives 6. Both lose to R4's flags and both win over a divide.
- R6: A divide (`is_div` = 1) with `denom` equal to 0 gives 7 (division error), signed or unsigned.
- R7: A signed divide (`is_div` = 1 and `is_sdiv` = 1) of `numer` = 0x80000000 by `denom` = 0xFFFFFFFF gives 7. The same operands on an unsigned divide, and any other nonzero operands, do not.
- R8: A snapshot that matches no check gives 15 (unknown). This includes a divide that hits neither error condition. `cause_now` is never 0.
- R9: On a rising clock edge with `exc_taken` high, `cause_q` takes the value `cause_now` had before the edge. On edges with `exc_taken` low, it keeps its value.
- R10: `is_sdiv` has no effect unless `is_div` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prev_ie | input | 1 | Saved interrupt-enable bit from before the exception |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| is_trap | input | 1 | Faulting instruction is a trap |
| is_ldst | input | 1 | Faulting instruction is a load or store |
| is_xfer | input | 1 | Faulting instruction is a control transfer |
| is_unimp | input | 1 | Faulting instruction is unimplemented |
| is_illegal | input | 1 | Faulting instruction is illegal |
| is_div | input | 1 | Faulting instruction is a divide |
| is_sdiv | input | 1 | The divide is signed |
| numer | input | DATA_W | Divide numerator |
| denom | input | DATA_W | Divide denominator |
| exc_taken | input | 1 | Exception-taken strobe, loads the cause register |
| cause_now | output | 4 | Combinational cause code |
| cause_q | output | 4 | Registered cause code |

## Verification
The assertions assume the snapshot inputs are clean, known values whenever the clock rises out of reset. They also assume `exc_taken` is a plain level sampled at the edge, with no other relation to the flags. The bench changes every input only on the falling edge. It holds them steady across each rising edge. It also deliberately sets several flags at once, so that the priority properties see overlapping requests and not only single-flag snapshots.

// File: rtl/exc_cause_classifier.sv
module exc_cause_classifier #(
  parameter int DATA_W  = 32,
  parameter int IRQ_W   = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prev_ie,
  input  logic [IRQ_W-1:0]   irq_pend,
  input  logic               is_trap,
  input  logic               is_ldst,
  input  logic               is_xfer,
  input  logic               is_unimp,
  input  logic               is_illegal,
  input  logic               is_div,
  input  logic               is_sdiv,
  input  logic [DATA_W-1:0]  numer,
  input  logic [DATA_W-1:0]  denom,
  input  logic               exc_taken,
  output logic [CAUSE_W-1:0] cause_now,
  output logic [CAUSE_W-1:0] cause_q
);
  localparam logic [CAUSE_W-1:0] C_NONE  = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] C_IRQ   = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] C_TRAP  = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] C_DADDR = CAUSE_W'(3);
  localparam logic [CAUSE_W-1:0] C_JADDR = CAUSE_W'(4);
  localparam logic [CAUSE_W-1:0] C_UNIMP = CAUSE_W'(5);
  localparam logic [CAUSE_W-1:0] C_ILLEG = CAUSE_W'(6);
  localparam logic [CAUSE_W-1:0] C_DIVER = CAUSE_W'(7);
  localparam logic [CAUSE_W-1:0] C_UNKN  = {CAUSE_W{1'b1}};
  localparam logic [DATA_W-1:0]  MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0]  MINUS_1  = {DATA_W{1'b1}};

  logic irq_hit, div_zero, div_ovf, div_err;

  assign irq_hit  = prev_ie && (|irq_pend);
  assign div_zero = (denom == '0);
  assign div_ovf  = is_sdiv && (numer == MOST_NEG) && (denom == MINUS_1);
  assign div_err  = is_div && (div_zero || div_ovf);

  always_comb begin
    if (irq_hit)         cause_now = C_IRQ;
    else if (is_trap)    cause_now = C_TRAP;
    else if (is_ldst)    cause_now = C_DADDR;
    else if (is_xfer)    cause_now = C_JADDR;
    else if (is_unimp)   cause_now = C_UNIMP;
    else if (is_illegal) cause_now = C_ILLEG;
    else if (div_err)    cause_now = C_DIVER;
    else                 cause_now = C_UNKN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cause_q <= C_NONE;
    else if (exc_taken) cause_q <= cause_now;
  end
endmodule

module exc_cause_classifier_chk #(
  parameter int DATA_W  = 32,
  parameter int IRQ_W   = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               prev_ie,
  input logic [IRQ_W-1:0]   irq_pend,
  input logic               is_trap,
  input logic               is_ldst,
  input logic               is_xfer,
  input logic               is_div,
  input logic [DATA_W-1:0]  denom,
  input logic               exc_taken,
  input logic [CAUSE_W-1:0] cause_now,
  input logic [CAUSE_W-1:0] cause_q
);
  logic irq_on;
  assign irq_on = prev_ie && (irq_pend != '0);

  assert_irq_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_on |-> cause_now == CAUSE_W'(1));
  assert_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_on |-> cause_now != CAUSE_W'(1));
  assert_trap_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_on && is_trap) |-> cause_now == CAUSE_W'(2));
  assert_divzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_on && !is_trap && !is_ldst && !is_xfer && is_div && denom == '0
     && cause_now != CAUSE_W'(5) && cause_now != CAUSE_W'(6)) |-> cause_now == CAUSE_W'(7));
  assert_never_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_now != '0);
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> cause_q == $past(cause_now));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |=> $stable(cause_q));
endmodule

bind exc_cause_classifier exc_cause_classifier_chk #(
  .DATA_W(DATA_W), .IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .prev_ie(prev_ie), .irq_pend(irq_pend),
  .is_trap(is_trap), .is_ldst(is_ldst), .is_xfer(is_xfer), .is_div(is_div),
  .denom(denom), .exc_taken(exc_taken), .cause_now(cause_now), .cause_q(cause_q)
);

// File: tb/exc_cause_classifier_tb_top.sv
module exc_cause_classifier_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prev_ie, is_trap, is_ldst, is_xfer, is_unimp, is_illegal, is_div, is_sdiv;
  logic        exc_taken;
  logic [31:0] irq_pend, numer, denom;
  logic [3:0]  cause_now, cause_q;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_cause_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .prev_ie(prev_ie), .irq_pend(irq_pend),
    .is_trap(is_trap), .is_ldst(is_ldst), .is_xfer(is_xfer), .is_unimp(is_unimp),
    .is_illegal(is_illegal), .is_div(is_div), .is_sdiv(is_sdiv),
    .numer(numer), .denom(denom), .exc_taken(exc_taken),
    .cause_now(cause_now), .cause_q(cause_q)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    prev_ie = 0; irq_pend = '0; is_trap = 0; is_ldst = 0; is_xfer = 0;
    is_unimp = 0; is_illegal = 0; is_div = 0; is_sdiv = 0;
    numer = 32'd1; denom = 32'd1; exc_taken = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic pulse();
    @(negedge clk) exc_taken = 1;
    @(negedge clk) exc_taken = 0;
    #1;
  endtask

  task automatic t_reset();
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", cause_q, 4'd0);
    rst_n = 1;
    is_trap = 1;
    repeat (2) settle();
    check("R1 after reset, no strobe", cause_q, 4'd0);
  endtask

  task automatic t_irq();
    clear_in();
    prev_ie = 1; irq_pend = 32'h0000_0020;
    is_trap = 1; is_ldst = 1; is_xfer = 1; is_unimp = 1; is_illegal = 1; is_div = 1; denom = 0;
    settle(); check("R2 irq over all flags", cause_now, 4'd1);
    irq_pend = 32'h8000_0000;
    settle(); check("R2 top line only", cause_now, 4'd1);
  endtask

  task automatic t_irq_masked();
    clear_in();
    irq_pend = 32'hFFFF_FFFF; is_trap = 1;
    settle(); check("R3 ie=0 pending", cause_now, 4'd2);
    prev_ie = 1; irq_pend = '0;
    settle(); check("R3 ie=1 nothing pending", cause_now, 4'd2);
  endtask

  task automatic t_order_hi();
    clear_in();
    is_trap = 1; is_ldst = 1; is_xfer = 1; is_unimp = 1;
    settle(); check("R4 trap first", cause_now, 4'd2);
    is_trap = 0;
    settle(); check("R4 load/store next", cause_now, 4'd3);
    is_ldst = 0;
    settle(); check("R4 transfer next", cause_now, 4'd4);
  endtask

  task automatic t_order_lo();
    clear_in();
    is_unimp = 1; is_illegal = 1; is_div = 1; denom = 0;
    settle(); check("R5 unimplemented", cause_now, 4'd5);
    is_unimp = 0;
    settle(); check("R5 illegal over divide", cause_now, 4'd6);
  endtask

  task automatic t_divzero();
    clear_in();
    is_div = 1; numer = 32'd77; denom = 0;
    settle(); check("R6 unsigned by zero", cause_now, 4'd7);
    is_sdiv = 1;
    settle(); check("R6 signed by zero", cause_now, 4'd7);
  endtask

  task automatic t_ovf();
    clear_in();
    is_div = 1; is_sdiv = 1; numer = 32'h8000_0000; denom = 32'hFFFF_FFFF;
    settle(); check("R7 signed overflow", cause_now, 4'd7);
    is_sdiv = 0;
    settle(); check("R7 unsigned same operands", cause_now, 4'd15);
    is_sdiv = 1; denom = 32'hFFFF_FFFE;
    settle(); check("R7 denom off by one", cause_now, 4'd15);
    numer = 32'h8000_0001; denom = 32'hFFFF_FFFF;
    settle(); check("R7 numer off by one", cause_now, 4'd15);
  endtask

  task automatic t_unknown();
    clear_in();
    settle(); check("R8 no flags", cause_now, 4'd15);
    is_div = 1; numer = 32'd10; denom = 32'd3;
    settle(); check("R8 clean divide", cause_now, 4'd15);
  endtask

  task automatic t_sdiv_alone();
    clear_in();
    is_sdiv = 1; numer = 32'h8000_0000; denom = 32'hFFFF_FFFF;
    settle(); check("R10 signed flag without divide", cause_now, 4'd15);
    denom = 0;
    settle(); check("R10 signed flag, zero denom, no divide", cause_now, 4'd15);
  endtask

  task automatic t_capture();
    clear_in();
    is_trap = 1;
    pulse(); check("R9 load trap", cause_q, 4'd2);
    is_trap = 0; is_illegal = 1;
    repeat (3) settle();
    check("R9 hold without strobe", cause_q, 4'd2);
    pulse(); check("R9 load illegal", cause_q, 4'd6);
    @(negedge clk) begin exc_taken = 1; is_illegal = 0; prev_ie = 1; irq_pend = 32'd1; end
    @(negedge clk) begin is_div = 0; prev_ie = 0; is_ldst = 1; end
    @(negedge clk) exc_taken = 0;
    #1 check("R9 long strobe keeps last", cause_q, 4'd3);
    clear_in();
    repeat (2) settle();
    check("R9 hold after long strobe", cause_q, 4'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_irq();
    t_irq_masked();
    t_order_hi();
    t_order_lo();
    t_divzero();
    t_ovf();
    t_unknown();
    t_sdiv_alone();
    t_capture();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule